// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block raises a periodic interrupt pulse that tells a processor to poll its accumulation status registers. A 13-bit down-counter runs from a preset value to zero. When it reaches zero it reloads the preset and the block emits a pulse on `irq_o`. The counter does not advance on every clock. A prescaler gives it one step every seven system clocks, so with preset P the interrupt repeats every 7·(P+1) system clocks.

The preset can be changed in two ways. A write strobe with data loads any 13-bit value. Any change on the one-bit `period_sel_i` input loads one of two fixed periods. Both paths overwrite the preset register. A new preset only takes effect when the counter next wraps from zero, so the period already in progress finishes unchanged. The bus decoder and the interrupt controller are outside the block. The reset input is expected to be deasserted synchronously to `clk`.

Top module: `poll_irq_timer`

## Requirements
- R1: With preset P the count runs P, P−1, …, 1, 0 and then reloads P, so interrupts are spaced (P+1) counter steps apart; P = 0 gives an interrupt on every step.
- R2: The counter takes exactly one step every 7 system clocks and holds its value in the other six clocks.
- R3: `irq_o` is high for exactly one system clock: the step cycle in which the count is zero.
- R4: While reset is held, `irq_o` is low. Reset clears the prescaler and sets both the preset and the count to 0x0B45. After release the first interrupt is therefore seen in clock 7·2886−1 = 20201, counting the first rising edge after release as 1.
- R5: A write with `wr_en_i` high loads `wr_data_i[12:0]` into the preset. Data bits 15:13 are ignored.
- R6: A transition on `period_sel_i` loads the preset. A rising transition (new value 1) loads 0x1313, giving a period of 34188 clocks. A falling transition (new value 0) loads 0x0B45, giving a period of 20202 clocks.
- R7: If a write and a `period_sel_i` transition occur in the same clock, the written value wins.
- R8: A preset change does not disturb the count in progress. It is used first at the next reload from zero.
- R9: The level of `period_sel_i` during and just after reset is taken as the reference. It causes no preset load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| period_sel_i | input | 1 | Period select; each transition loads a fixed preset |
| wr_en_i | input | 1 | Write strobe for the programmable period |
| wr_data_i | input | 16 | Write data; bits 12:0 form the new preset |
| irq_o | output | 1 | One-clock interrupt pulse at each wrap |

## Verification
The bench changes the preset right on the interrupt cycle and checks that the following period still uses the old value. A design that reloads immediately would give a short period instead of the expected one. It holds `period_sel_i` high through reset; a design that sees that level as an edge would load 0x1313 and stretch the second period to 34188 clocks. It writes a value with the top data bits set, and a design that kept those bits would time a period far longer than 42 clocks. It also writes in the same cycle as a select transition, where a design with the wrong priority would give a 20202-clock period instead of 35. A zero preset checks that the counter fires on every step without skipping.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned PIT_CNT_W   = 13;
  localparam int unsigned PIT_DATA_W  = 16;
  localparam int unsigned PIT_DIV     = 7;
  localparam logic [PIT_CNT_W-1:0] PIT_PRESET_SEL0 = 13'h0B45;
  localparam logic [PIT_CNT_W-1:0] PIT_PRESET_SEL1 = 13'h1313;
endpackage

// File: rtl/pit_prescaler.sv
module pit_prescaler #(
  parameter int unsigned DIV = pit_pkg::PIT_DIV
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;
  logic [PW-1:0] div_d;

  always_comb begin
    tick_o = (div_q == LAST);
    div_d  = tick_o ? '0 : div_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= LAST);  // R2
  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);  // R2
endmodule

// File: rtl/pit_preset_reg.sv
module pit_preset_reg #(
  parameter int unsigned CNT_W  = pit_pkg::PIT_CNT_W,
  parameter int unsigned DATA_W = pit_pkg::PIT_DATA_W,
  parameter logic [CNT_W-1:0] SEL0_VAL = pit_pkg::PIT_PRESET_SEL0,
  parameter logic [CNT_W-1:0] SEL1_VAL = pit_pkg::PIT_PRESET_SEL1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CNT_W-1:0]  preset_o
);
  logic             armed_q;
  logic             sel_q;
  logic             sel_edge;
  logic [CNT_W-1:0] preset_q;
  logic [CNT_W-1:0] preset_d;

  generate
    if (DATA_W > CNT_W) begin : g_drop_hi
      logic unused_hi;
      assign unused_hi = ^wr_data_i[DATA_W-1:CNT_W];
    end
  endgenerate

  // The reference is taken in the first clock after reset, so no edge is seen then.
  always_comb begin
    sel_edge = armed_q && (sel_i != sel_q);
    preset_d = preset_q;
    if (wr_en_i)       preset_d = wr_data_i[CNT_W-1:0];
    else if (sel_edge) preset_d = sel_i ? SEL1_VAL : SEL0_VAL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      sel_q    <= 1'b0;
      preset_q <= SEL0_VAL;
    end else begin
      armed_q  <= 1'b1;
      sel_q    <= sel_i;
      preset_q <= preset_d;
    end
  end

  assign preset_o = preset_q;

  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> preset_q == $past(wr_data_i[CNT_W-1:0]));  // R5
  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_edge && !wr_en_i) |=> preset_q == ($past(sel_i) ? SEL1_VAL : SEL0_VAL));  // R6
  AST_PRESET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && !sel_edge) |=> $stable(preset_q));  // R9
endmodule

// File: rtl/pit_downcounter.sv
module pit_downcounter #(
  parameter int unsigned CNT_W = pit_pkg::PIT_CNT_W,
  parameter logic [CNT_W-1:0] RST_VAL = pit_pkg::PIT_PRESET_SEL0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_zero;

  always_comb begin
    at_zero = (cnt_q == '0);
    wrap_o  = tick_i && at_zero;
    cnt_d   = cnt_q;
    if (tick_i) cnt_d = at_zero ? preset_i : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt_q));  // R2
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));  // R1
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && cnt_q == '0) |=> cnt_q == $past(preset_i));  // R8
endmodule

// File: rtl/poll_irq_timer.sv
module poll_irq_timer #(
  parameter int unsigned CNT_W  = pit_pkg::PIT_CNT_W,
  parameter int unsigned DATA_W = pit_pkg::PIT_DATA_W,
  parameter int unsigned DIV    = pit_pkg::PIT_DIV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] SEL0_VAL = CNT_W'(pit_pkg::PIT_PRESET_SEL0);
  localparam logic [CNT_W-1:0] SEL1_VAL = CNT_W'(pit_pkg::PIT_PRESET_SEL1);

  logic             tick;
  logic [CNT_W-1:0] preset;

  pit_prescaler #(.DIV(DIV)) u_prescaler (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  pit_preset_reg #(
    .CNT_W    (CNT_W),
    .DATA_W   (DATA_W),
    .SEL0_VAL (SEL0_VAL),
    .SEL1_VAL (SEL1_VAL)
  ) u_preset (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (period_sel_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .preset_o  (preset)
  );

  pit_downcounter #(
    .CNT_W   (CNT_W),
    .RST_VAL (SEL0_VAL)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .preset_i (preset),
    .wrap_o   (irq_o)
  );

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);  // R3
  AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> tick);  // R2
endmodule

// File: tb/poll_irq_timer_bench.sv
`timescale 1ns/1ps
module poll_irq_timer_bench;
  logic        clk;
  logic        rst_n;
  logic        period_sel_i;
  logic        wr_en_i;
  logic [15:0] wr_data_i;
  logic        irq_o;

  int n_checks;
  int n_fail;
  int edges;
  logic irq_d;
  int p_prev;
  int p_now;

  poll_irq_timer u_poll_irq_timer (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_sel_i (period_sel_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .irq_o        (irq_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) edges <= edges + 1;

  always @(negedge clk) begin
    if (rst_n && irq_o && irq_d) begin
      n_fail++;
      $display("FAIL R3: irq high two clocks in a row at clock %0d (actual 1, expected 0)", edges);
    end
    irq_d <= irq_o;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Returns at the negedge on which a pulse is seen; the previous clock must be low (R3).
  task automatic wait_pulse(output int at);
    do @(negedge clk); while (!irq_o);
    at = edges;
    check("R3 rise from low", int'(irq_d), 0);
  endtask

  task automatic drive_write(input logic [15:0] d);
    wr_en_i   = 1'b1;
    wr_data_i = d;
    @(negedge clk);
    wr_en_i   = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; period_sel_i = 1'b1; wr_en_i = 1'b0; wr_data_i = '0;
    edges = 0; irq_d = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 irq low in reset", int'(irq_o), 0);
    rst_n = 1'b1;
    wait_pulse(p_now);
    check("R4 first pulse clock", p_now, 20201);
  endtask

  task automatic t_write_deferred;
    p_prev = p_now;
    drive_write(16'h0003);
    wait_pulse(p_now);
    check("R8 R9 period after write", p_now - p_prev, 20202);
    p_prev = p_now;
    wait_pulse(p_now);
    check("R1 period P=3", p_now - p_prev, 28);
  endtask

  task automatic t_upper_bits;
    p_prev = p_now;
    drive_write(16'hE005);
    wait_pulse(p_now);
    check("R8 old period kept", p_now - p_prev, 28);
    p_prev = p_now;
    wait_pulse(p_now);
    check("R5 upper bits ignored P=5", p_now - p_prev, 42);
  endtask

  task automatic t_zero;
    p_prev = p_now;
    drive_write(16'h0000);
    wait_pulse(p_now);
    check("R8 period before zero", p_now - p_prev, 42);
    p_prev = p_now;
    wait_pulse(p_now);
    check("R1 R2 period P=0", p_now - p_prev, 7);
    p_prev = p_now;
    wait_pulse(p_now);
    check("R2 period P=0 again", p_now - p_prev, 7);
  endtask

  task automatic t_sel_and_priority;
    period_sel_i = 1'b0;
    @(negedge clk);
    period_sel_i = 1'b1;
    p_prev = p_now;
    wait_pulse(p_now);
    check("R8 step before select", p_now - p_prev, 7);
    p_prev = p_now;
    period_sel_i = 1'b0;
    drive_write(16'h0004);
    wait_pulse(p_now);
    check("R6 rising select period", p_now - p_prev, 34188);
    p_prev = p_now;
    wait_pulse(p_now);
    check("R7 write wins over select", p_now - p_prev, 35);
  endtask

  task automatic t_sel_falling;
    period_sel_i = 1'b1;
    @(negedge clk);
    period_sel_i = 1'b0;
    p_prev = p_now;
    wait_pulse(p_now);
    check("R8 period before falling load", p_now - p_prev, 35);
    p_prev = p_now;
    wait_pulse(p_now);
    check("R6 falling select period", p_now - p_prev, 20202);
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    t_reset();
    t_write_deferred();
    t_upper_bits();
    t_zero();
    t_sel_and_priority();
    t_sel_falling();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run hung (actual timeout, expected completion)");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule